// File: doc/BRIEF.md
# Bit-Stuffing Serial Frame Transmitter

This block turns byte-wide frame contents into a bit-serial line for a bit-oriented data link. Bytes arrive on a ready/valid port with a marker on the final byte of each frame. The block first raises its request-to-send output and waits for clear-to-send. It then frames the payload between flag octets and appends a 16-bit frame check sequence. Whenever five ones have gone out in a row inside the frame body, it inserts a zero.

Every line bit is timed by a one-cycle enable, `bit_en`, which the surrounding logic derives from the external transmit clock. If a frame runs dry before its last byte, the block aborts it with a run of ones and closes the line with a flag. When another frame is already waiting at the closing flag, the next opening flag follows at once. Otherwise request-to-send is released one bit time later and the line rests at one.

Top module: `bitlink_tx`

## Requirements
- R1: While reset is applied and just after it is released, `txd` is 1, `rts_o` is 0 and `in_ready` is 0.
- R2: `txd` changes only on a clock edge at which `bit_en` is 1. Each such edge moves out exactly one line bit.
- R3: `rts_o` rises on a `bit_en` edge at which `in_valid` is 1. `txd` stays 1 until `cts_i` has been seen high while `rts_o` is high. The opening flag starts on the bit time after that.
- R4: Every frame opens and closes with the flag 0x7E (line order 0,1,1,1,1,1,1,0). Flag bits are never stuffed.
- R5: Payload bytes are sent in arrival order, bit 0 first.
- R6: Within payload and check-sequence bits, a 0 is inserted immediately after every run of five consecutive 1s. This includes a run that ends on the last check-sequence bit, so the inserted 0 comes before the closing flag.
- R7: The check sequence is a CRC over the payload bits with generator x^16+x^12+x^5+1, preset to all ones and processed bit 0 first. Its ones-complement is sent, bit 0 first.
- R8: If a byte is already offered when the closing flag ends, the next frame's opening flag follows directly and `rts_o` stays high.
- R9: If no byte is offered when the closing flag ends, `rts_o` falls at the next bit time and `txd` holds 1 while `rts_o` is low.
- R10: If `in_valid` is low when a non-final byte has been fully sent, the block sends eight 1s (after any pending stuffed 0) and then one flag.
- R11: `in_ready` is high only in a cycle where `bit_en` and `rts_o` are both high. A byte is taken when `in_ready` and `in_valid` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en | input | 1 | One-cycle enable per line bit, from the transmit clock |
| in_data | input | 8 | Frame byte |
| in_valid | input | 1 | `in_data` holds a byte |
| in_last | input | 1 | The offered byte ends its frame |
| in_ready | output | 1 | Byte accepted this cycle when `in_valid` is high |
| rts_o | output | 1 | Request-to-send |
| cts_i | input | 1 | Clear-to-send |
| txd | output | 1 | Serial line data |

## Verification
An error in the ones-run count or the bit index shows on `txd` within one bit time. It appears as a missing or extra 0, which shifts every later bit of the frame. A corrupted CRC register is seen only in the check-sequence bits, up to 16 bit times after the last payload byte. A wrong state transition shows as a flag, abort or idle level at the wrong bit position, or as `rts_o` failing to rise or fall on the expected bit time. For this reason the bench compares the whole line stream bit by bit, from the first 0 of each opening flag.

// File: rtl/bitlink_pkg.sv
package bitlink_pkg;
  localparam int BYTE_W = 8;
  localparam int FCS_W = 16;
  localparam logic [BYTE_W-1:0] FLAG_OCTET = 8'h7E;
  localparam logic [FCS_W-1:0] FCS_POLY_REFL = 16'h8408;
  localparam logic [FCS_W-1:0] FCS_PRESET = 16'hFFFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CTS,
    ST_OPEN,
    ST_DATA,
    ST_FCS,
    ST_ABORT,
    ST_CLOSE
  } tx_state_e;
endpackage

// File: rtl/rst_sync.sv
module rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic srst_n_o
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) stage_q <= '0;
    else          stage_q <= {stage_q[0], 1'b1};
  end

  assign srst_n_o = stage_q[1];
endmodule

// File: rtl/fcs_step.sv
module fcs_step #(
  parameter int              W    = 16,
  parameter logic [W-1:0]    POLY = 16'h8408
) (
  input  logic [W-1:0] crc_i,
  input  logic         bit_i,
  output logic [W-1:0] crc_o
);
  logic feedback;

  always_comb begin
    feedback = crc_i[0] ^ bit_i;
    crc_o    = (crc_i >> 1) ^ (feedback ? POLY : '0);
  end
endmodule

// File: rtl/run_guard.sv
module run_guard #(
  parameter int RUN_LEN = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic bit_val,
  input  logic countable,
  output logic stuff_now
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] run_q, run_d;

  assign stuff_now = (run_q == CW'(RUN_LEN));

  always_comb begin
    run_d = run_q;
    if (step) begin
      if (stuff_now || !countable || !bit_val) run_d = '0;
      else                                     run_d = run_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= run_d;
  end
endmodule

// File: rtl/bitlink_tx.sv
module bitlink_tx #(
  parameter int RUN_LEN   = 5,
  parameter int ABORT_LEN = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bit_en,
  input  logic [7:0] in_data,
  input  logic       in_valid,
  input  logic       in_last,
  output logic       in_ready,
  output logic       rts_o,
  input  logic       cts_i,
  output logic       txd
);
  import bitlink_pkg::*;

  localparam int IDX_W = $clog2(FCS_W + ABORT_LEN);
  localparam logic [IDX_W-1:0] BYTE_END  = IDX_W'(BYTE_W - 1);
  localparam logic [IDX_W-1:0] FCS_END   = IDX_W'(FCS_W - 1);
  localparam logic [IDX_W-1:0] ABORT_END = IDX_W'(ABORT_LEN - 1);

  tx_state_e         state_q, state_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic [FCS_W-1:0]  sh_q, sh_d;
  logic [FCS_W-1:0]  crc_q, crc_d, crc_step_w;
  logic              last_q, last_d;
  logic              rts_q, rts_d;
  logic              txd_q, txd_d;
  logic              srst_n;
  logic              src_bit, countable, stuff_now, advance;

  rst_sync u_rst (.clk(clk), .rst_n_i(rst_n), .srst_n_o(srst_n));

  fcs_step #(.W(FCS_W), .POLY(FCS_POLY_REFL)) u_fcs (
    .crc_i(crc_q), .bit_i(sh_q[0]), .crc_o(crc_step_w)
  );

  run_guard #(.RUN_LEN(RUN_LEN)) u_run (
    .clk(clk), .rst_n(srst_n), .step(bit_en), .bit_val(src_bit),
    .countable(countable), .stuff_now(stuff_now)
  );

  // bit source for the current state
  always_comb begin
    src_bit   = 1'b1;
    countable = 1'b0;
    case (state_q)
      ST_OPEN, ST_CLOSE: src_bit = FLAG_OCTET[idx_q[2:0]];
      ST_DATA, ST_FCS: begin
        src_bit   = sh_q[0];
        countable = 1'b1;
      end
      default: src_bit = 1'b1;
    endcase
  end

  assign advance  = bit_en && !stuff_now;
  assign in_ready = advance && (idx_q == BYTE_END) &&
                    ((state_q == ST_OPEN) || ((state_q == ST_DATA) && !last_q));

  // next-state logic
  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    sh_d    = sh_q;
    crc_d   = crc_q;
    last_d  = last_q;
    rts_d   = rts_q;
    txd_d   = txd_q;
    if (bit_en) txd_d = stuff_now ? 1'b0 : src_bit;
    if (advance) begin
      idx_d = idx_q + 1'b1;
      case (state_q)
        ST_IDLE: begin
          idx_d = '0;
          rts_d = in_valid;
          if (in_valid) state_d = ST_WAIT_CTS;
        end
        ST_WAIT_CTS: begin
          idx_d = '0;
          if (cts_i) state_d = ST_OPEN;
        end
        ST_OPEN: begin
          if (idx_q == BYTE_END) begin
            idx_d = '0;
            if (in_valid) begin
              state_d = ST_DATA;
              sh_d    = {{(FCS_W-BYTE_W){1'b0}}, in_data};
              last_d  = in_last;
              crc_d   = FCS_PRESET;
            end else begin
              state_d = ST_IDLE;
            end
          end
        end
        ST_DATA: begin
          crc_d = crc_step_w;
          sh_d  = sh_q >> 1;
          if (idx_q == BYTE_END) begin
            idx_d = '0;
            if (last_q) begin
              state_d = ST_FCS;
              sh_d    = ~crc_step_w;
            end else if (in_valid) begin
              sh_d   = {{(FCS_W-BYTE_W){1'b0}}, in_data};
              last_d = in_last;
            end else begin
              state_d = ST_ABORT;
            end
          end
        end
        ST_FCS: begin
          sh_d = sh_q >> 1;
          if (idx_q == FCS_END) begin
            idx_d   = '0;
            state_d = ST_CLOSE;
          end
        end
        ST_ABORT: begin
          if (idx_q == ABORT_END) begin
            idx_d   = '0;
            state_d = ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (idx_q == BYTE_END) begin
            idx_d   = '0;
            state_d = in_valid ? ST_OPEN : ST_IDLE;
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      sh_q    <= '0;
      crc_q   <= FCS_PRESET;
      last_q  <= 1'b0;
      rts_q   <= 1'b0;
      txd_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      sh_q    <= sh_d;
      crc_q   <= crc_d;
      last_q  <= last_d;
      rts_q   <= rts_d;
      txd_q   <= txd_d;
    end
  end

  assign rts_o = rts_q;
  assign txd   = txd_q;
endmodule

// File: rtl/bitlink_tx_chk.sv
module bitlink_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic bit_en,
  input logic in_valid,
  input logic in_ready,
  input logic rts_o,
  input logic cts_i,
  input logic txd
);
  logic seen_cts;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                seen_cts <= 1'b0;
    else if (!rts_o)           seen_cts <= 1'b0;
    else if (cts_i)            seen_cts <= 1'b1;
  end

  // R2
  txd_paced_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(txd));

  // R9
  idle_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_o |-> txd);

  // R3
  cts_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> seen_cts);

  // R3
  rts_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rts_o) |-> ($past(in_valid) && $past(bit_en)));

  // R11
  ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> (bit_en && rts_o));
endmodule

bind bitlink_tx bitlink_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_valid(in_valid),
  .in_ready(in_ready), .rts_o(rts_o), .cts_i(cts_i), .txd(txd)
);

// File: tb/sim_bitlink_tx.sv
`timescale 1ns/1ps
module sim_bitlink_tx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_en = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic       in_valid = 1'b0;
  logic       in_last = 1'b0;
  logic       in_ready;
  logic       rts_o;
  logic       cts_i = 1'b1;
  logic       txd;

  int checks = 0;
  int failures = 0;

  bit         exp_q[$];
  string      tag_q[$];
  logic [7:0] pay_q[$];
  int         ones = 0;
  logic [15:0] crc;

  logic [1:0] div_cnt = 2'd0;
  logic       pe = 1'b0;
  bit         started = 0;
  bit         chk_drop = 0;
  logic       last_txd = 1'b1;

  always #2 clk = ~clk;

  bitlink_tx u0 (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .in_data(in_data),
    .in_valid(in_valid), .in_last(in_last), .in_ready(in_ready),
    .rts_o(rts_o), .cts_i(cts_i), .txd(txd)
  );

  always @(posedge clk) begin
    div_cnt <= div_cnt + 2'd1;
    bit_en  <= (div_cnt == 2'd2);
    pe      <= bit_en;
  end

  task automatic report(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, expv, $time);
    end
  endtask

  // expected-stream model
  task automatic put(input bit b, input string t, input bit stuffable);
    exp_q.push_back(b); tag_q.push_back(t);
    if (stuffable) begin
      ones = b ? ones + 1 : 0;
      if (ones == 5) begin
        exp_q.push_back(1'b0); tag_q.push_back("R6");
        ones = 0;
      end
    end else begin
      ones = 0;
    end
  endtask

  task automatic put_flag(input string t);
    for (int i = 0; i < 8; i++) put(8'h7E >> i, t, 1'b0);
  endtask

  task automatic put_payload();
    crc = 16'hFFFF;
    foreach (pay_q[k]) begin
      for (int i = 0; i < 8; i++) begin
        put(pay_q[k][i], "R5", 1'b1);
        crc = (crc >> 1) ^ (((crc[0] ^ pay_q[k][i]) != 1'b0) ? 16'h8408 : 16'h0000);
      end
    end
  endtask

  task automatic expect_frame(input string ftag);
    logic [15:0] fcs;
    put_flag(ftag);
    put_payload();
    fcs = ~crc;
    for (int i = 0; i < 16; i++) put(fcs[i], "R7", 1'b1);
    put_flag(ftag);
  endtask

  task automatic expect_abort();
    put_flag("R4");
    put_payload();
    for (int i = 0; i < 8; i++) put(1'b1, "R10", 1'b0);
    put_flag("R10");
  endtask

  // driver
  task automatic push_byte(input logic [7:0] d, input bit l);
    in_valid = 1'b1; in_data = d; in_last = l;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic drive_payload();
    foreach (pay_q[k]) push_byte(pay_q[k], k == pay_q.size() - 1);
  endtask

  task automatic stop_input();
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  task automatic wait_done();
    while (exp_q.size() != 0 || chk_drop) @(posedge clk);
    @(negedge clk);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (in_ready) report(bit_en && rts_o, "R11", {bit_en, rts_o}, 3);
      if (!pe) begin
        checks++;
        if (txd !== last_txd) begin
          failures++;
          $display("FAIL R2 actual=%0d expected=%0d t=%0t", txd, last_txd, $time);
        end
      end else if (chk_drop) begin
        report(rts_o === 1'b0 && txd === 1'b1, "R9", {rts_o, txd}, 1);
        chk_drop = 0;
      end else if (exp_q.size() > 0 && (started || txd === 1'b0)) begin
        bit    e;
        string t;
        started = 1;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        report(txd === e, t, txd, e);
        if (exp_q.size() == 0) begin
          started = 0;
          report(rts_o === 1'b1, "R9", rts_o, 1);
          chk_drop = 1;
        end
      end
    end
    last_txd = txd;
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    report(txd === 1'b1 && rts_o === 1'b0 && in_ready === 1'b0, "R1", {txd, rts_o, in_ready}, 4);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report(txd === 1'b1 && rts_o === 1'b0 && in_ready === 1'b0, "R1", {txd, rts_o, in_ready}, 4);

    // R3: hold off clear-to-send, line must stay marking
    cts_i = 1'b0;
    pay_q = '{8'h01, 8'hFF, 8'h7E, 8'hF8};
    expect_frame("R4");
    fork
      drive_payload();
      begin
        repeat (40) @(negedge clk);
        report(rts_o === 1'b1 && txd === 1'b1 && !started, "R3", {rts_o, txd}, 3);
        cts_i = 1'b1;
      end
    join
    stop_input();
    wait_done();

    // single byte of zeros
    pay_q = '{8'h00};
    expect_frame("R4");
    drive_payload();
    stop_input();
    wait_done();

    // run of ones across bytes (R6)
    pay_q = '{8'hFF, 8'hFF, 8'h1F, 8'h3E};
    expect_frame("R6");
    drive_payload();
    stop_input();
    wait_done();

    // back-to-back frames (R8)
    pay_q = '{8'hAA, 8'h55};
    expect_frame("R8");
    pay_q = '{8'hFF};
    expect_frame("R8");
    pay_q = '{8'hAA, 8'h55};
    drive_payload();
    pay_q = '{8'hFF};
    drive_payload();
    stop_input();
    wait_done();

    // underrun abort (R10)
    pay_q = '{8'hFF};
    expect_abort();
    push_byte(8'hFF, 1'b0);
    stop_input();
    wait_done();

    // more payload patterns for the check sequence (R7)
    pay_q = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
    expect_frame("R7");
    drive_payload();
    stop_input();
    wait_done();

    repeat (20) @(negedge clk);
    report(rts_o === 1'b0 && txd === 1'b1, "R9", {rts_o, txd}, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule